// File: doc/BRIEF.md
# Receive frame status classifier

This block follows a received frame as a stream of bytes, one byte per accepted beat, and builds the low half of the receive status word that a DMA engine writes back into a descriptor. It counts the bytes of the frame, picks up the 16-bit length/type field from byte offsets 12 and 13, and decides whether the frame carries an EtherType or an IEEE 802.3 length. For length-coded frames it compares the length field with the bytes actually received. It flags runt and oversized frames and folds the error inputs into one summary bit.

Sideband inputs are sampled on the beat that carries the end-of-frame marker. They are the CRC verdict, the odd-nibble indication, watchdog truncation, FIFO overflow, VLAN tagging and the results from an external checksum engine. When checksum offload is switched on, bits 7, 5 and 0 of the status word carry an encoded checksum verdict. When it is off, those bits carry the giant flag, the frame type and zero. The status word, the byte count and a runt flag are registered. They are presented with a one-cycle valid strobe in the cycle after the end-of-frame beat.

Top module: `rx_frame_status`

## Requirements
- R1: One clock edge after a beat with `in_valid` and `in_eof` high, `st_valid` is high for exactly one cycle. At that point `st_len` equals the number of beats from the `in_sof` beat through the `in_eof` beat. Bits 14, 13, 9, 8, 6 and 3 of `st_word` are always 0.
- R2: With offload off, bit 5 is 1 exactly when the frame has at least 14 bytes and the big-endian value of bytes 12 and 13 is 1536 or more.
- R3: A frame shorter than 14 bytes sets `st_runt`. It is treated as length-coded: bit 5 = 0 and bit 12 = 0.
- R4: Bit 12 (length error) is 1 when all of the following hold: the frame is not a runt, its length field is below 1536, no CRC error is present, and field + 18 (+4 if VLAN-tagged) differs from the byte count.
- R5: Bit 1 copies the CRC-error input. A CRC error forces bit 12 to 0.
- R6: With offload off, bit 7 (giant) is 1 when the byte count exceeds a limit. The limit is 9022 with jumbo and VLAN, 9018 with jumbo alone, 2000 with 2K mode and no jumbo, 1522 with VLAN alone, and 1518 otherwise.
- R7: Bit 2 copies the odd-nibble input, bit 4 the watchdog input, bit 11 the overflow input and bit 10 the VLAN input.
- R8: Bit 15 is the OR of bits 1, 2, 4, 11 and 12 and the giant condition of R6. It applies in both offload modes.
- R9: With offload on, and for a non-runt EtherType frame, bits {5,7,0} are set by the first of these that applies:
  - not IP: 0,1,1
  - header error: 1,1,1
  - payload skipped: 0,0,1
  - payload error: 1,0,1
  - otherwise: 1,0,0
- R10: With offload on, a length-coded or runt frame gives bits {5,7,0} = 0,0,0 whatever the checksum inputs are. With offload off, bit 0 is 0.
- R11: While reset is held, and until the first end-of-frame beat, `st_valid` is 0 and `st_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte beat accepted |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_crc_err | input | 1 | CRC check failed (sampled at end) |
| in_dribble | input | 1 | Odd number of nibbles received |
| in_wdog | input | 1 | Frame cut by receive watchdog |
| in_ovf | input | 1 | Frame damaged by FIFO overflow |
| in_vlan | input | 1 | Frame carries a VLAN tag |
| cks_is_ip | input | 1 | Checksum engine saw IPv4/IPv6 |
| cks_hdr_err | input | 1 | IP header checksum mismatch |
| cks_pay_err | input | 1 | Payload checksum mismatch |
| cks_pay_skip | input | 1 | Payload check bypassed |
| cfg_jumbo | input | 1 | Jumbo size limits |
| cfg_2k | input | 1 | 2000-byte size limit |
| cfg_cks_en | input | 1 | Checksum offload encoding of bits 7/5/0 |
| st_valid | output | 1 | Status strobe |
| st_word | output | 16 | Status word bits 15..0 |
| st_len | output | 14 | Received byte count |
| st_runt | output | 1 | Frame shorter than 14 bytes |

## Verification
Suppose the beat counter or the captured length/type bytes go wrong. The first frame whose size or field straddles a boundary then shows a wrong `st_len`, a wrong bit 5 or a spurious bit 12, all in the strobe one cycle after that frame's end beat. A wrong giant-limit selection shows only at the exact limit and limit+1 sizes, so every mode is swept across that pair. A misordered checksum priority shows as a wrong 5/7/0 triple on the first vector whose checksum inputs combine two conditions. For that reason all sixteen input combinations are applied in both frame classes.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   localparam int STW       = 16;
   localparam int B_ESUM    = 15;
   localparam int B_LENERR  = 12;
   localparam int B_OVF     = 11;
   localparam int B_VLAN    = 10;
   localparam int B_HI      = 7;
   localparam int B_TYPE    = 5;
   localparam int B_WDOG    = 4;
   localparam int B_DRIB    = 2;
   localparam int B_CRC     = 1;
   localparam int B_LO      = 0;

   typedef struct packed {
      logic crc;
      logic drib;
      logic wdog;
      logic ovf;
      logic vlan;
   } side_t;

   typedef struct packed {
      logic is_ip;
      logic hdr_err;
      logic pay_err;
      logic pay_skip;
   } cks_t;
endpackage

// File: rtl/rfs_frame_track.sv
module rfs_frame_track #(
   parameter int CNT_W     = 14,
   parameter int HDR_BYTES = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [7:0]       in_data,
   output logic [CNT_W-1:0] total_len,
   output logic [15:0]      type_val
);
   localparam logic [CNT_W-1:0] HI_IDX  = CNT_W'(HDR_BYTES - 2);
   localparam logic [CNT_W-1:0] LO_IDX  = CNT_W'(HDR_BYTES - 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (HDR_BYTES < 2) begin : g_bad_hdr
      $error("rfs_frame_track: HDR_BYTES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx;
   logic [7:0]       hi_q, lo_q;

   assign idx       = in_sof ? '0 : cnt_q;
   assign total_len = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
   assign type_val  = {(idx == HI_IDX) ? in_data : hi_q,
                       (idx == LO_IDX) ? in_data : lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else if (in_valid) begin
         cnt_q <= total_len;
         if (idx == HI_IDX) hi_q <= in_data;
         if (idx == LO_IDX) lo_q <= in_data;
      end
   end

   // R1
   cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sof) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/rfs_giant_limit.sv
module rfs_giant_limit #(
   parameter int CNT_W      = 14,
   parameter int STD_MAX    = 1518,
   parameter int TWOK_MAX   = 2000,
   parameter int JUMBO_MAX  = 9018,
   parameter int VLAN_EXTRA = 4
) (
   input  logic [CNT_W-1:0] total_len,
   input  logic             vlan,
   input  logic             jumbo,
   input  logic             twok,
   output logic             giant
);
   localparam logic [CNT_W-1:0] L_STD   = CNT_W'(STD_MAX);
   localparam logic [CNT_W-1:0] L_STDV  = CNT_W'(STD_MAX + VLAN_EXTRA);
   localparam logic [CNT_W-1:0] L_TWOK  = CNT_W'(TWOK_MAX);
   localparam logic [CNT_W-1:0] L_JMB   = CNT_W'(JUMBO_MAX);
   localparam logic [CNT_W-1:0] L_JMBV  = CNT_W'(JUMBO_MAX + VLAN_EXTRA);

   if (!(STD_MAX < TWOK_MAX && TWOK_MAX < JUMBO_MAX)) begin : g_bad_lim
      $error("rfs_giant_limit: limits must rise standard < 2K < jumbo");
   end

   logic [CNT_W-1:0] limit;

   always_comb begin
      if (jumbo)     limit = vlan ? L_JMBV : L_JMB;
      else if (twok) limit = L_TWOK;
      else           limit = vlan ? L_STDV : L_STD;
   end

   assign giant = total_len > limit;

   // R6
   limit_floor_chk: assert final (limit >= L_STD);
endmodule

// File: rtl/rfs_cks_encode.sv
module rfs_cks_encode
   import rfs_pkg::*;
#(
   parameter bit HAS_CKS = 1'b1
) (
   input  logic  cks_on,
   input  logic  len_coded,
   input  logic  giant,
   input  cks_t  cks,
   output logic  b7,
   output logic  b5,
   output logic  b0
);
   typedef enum logic [2:0] {
      CV_LEN, CV_NOTIP, CV_BOTH, CV_SKIP, CV_PAY, CV_OK
   } cverdict_e;

   if (HAS_CKS) begin : g_cks
      cverdict_e v;
      always_comb begin
         if (len_coded)         v = CV_LEN;
         else if (!cks.is_ip)   v = CV_NOTIP;
         else if (cks.hdr_err)  v = CV_BOTH;
         else if (cks.pay_skip) v = CV_SKIP;
         else if (cks.pay_err)  v = CV_PAY;
         else                   v = CV_OK;
      end

      always_comb begin
         {b5, b7, b0} = {!len_coded, giant, 1'b0};
         if (cks_on) begin
            case (v)
               CV_NOTIP: {b5, b7, b0} = 3'b011;
               CV_BOTH:  {b5, b7, b0} = 3'b111;
               CV_SKIP:  {b5, b7, b0} = 3'b001;
               CV_PAY:   {b5, b7, b0} = 3'b101;
               CV_OK:    {b5, b7, b0} = 3'b100;
               default:  {b5, b7, b0} = 3'b000;
            endcase
         end
      end

      // R10
      len_zero_chk: assert final (!(cks_on && len_coded) || {b5, b7, b0} == 3'b000);
   end else begin : g_raw
      assign b5 = !len_coded;
      assign b7 = giant;
      assign b0 = 1'b0;
   end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
   import rfs_pkg::*;
#(
   parameter int CNT_W      = 14,
   parameter int HDR_BYTES  = 14,
   parameter int CRC_BYTES  = 4,
   parameter int TYPE_MIN   = 1536,
   parameter int STD_MAX    = 1518,
   parameter int TWOK_MAX   = 2000,
   parameter int JUMBO_MAX  = 9018,
   parameter int VLAN_EXTRA = 4,
   parameter bit HAS_CKS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   input  logic             in_crc_err,
   input  logic             in_dribble,
   input  logic             in_wdog,
   input  logic             in_ovf,
   input  logic             in_vlan,
   input  logic             cks_is_ip,
   input  logic             cks_hdr_err,
   input  logic             cks_pay_err,
   input  logic             cks_pay_skip,
   input  logic             cfg_jumbo,
   input  logic             cfg_2k,
   input  logic             cfg_cks_en,
   output logic             st_valid,
   output logic [15:0]      st_word,
   output logic [CNT_W-1:0] st_len,
   output logic             st_runt
);
   localparam int SUM_W = 17;
   localparam logic [SUM_W-1:0] FIXED_OVH = SUM_W'(HDR_BYTES + CRC_BYTES);
   localparam logic [SUM_W-1:0] TAG_OVH   = SUM_W'(VLAN_EXTRA);
   localparam logic [15:0]      TYPE_LIM  = 16'(TYPE_MIN);

   if (CNT_W > 16 || (1 << CNT_W) <= (JUMBO_MAX + VLAN_EXTRA)) begin : g_bad_w
      $error("rx_frame_status: CNT_W must hold the jumbo limit and stay within 16 bits");
   end
   if (TYPE_MIN >= 65536) begin : g_bad_type
      $error("rx_frame_status: TYPE_MIN must fit the 16-bit field");
   end

   side_t            side;
   cks_t             cks;
   logic [CNT_W-1:0] total_len;
   logic [15:0]      type_val;
   logic             runt, small_field, len_coded, len_err, giant;
   logic             b7, b5, b0;
   logic [SUM_W-1:0] want_len;
   logic [15:0]      word_d;

   assign side = '{crc: in_crc_err, drib: in_dribble, wdog: in_wdog,
                   ovf: in_ovf, vlan: in_vlan};
   assign cks  = '{is_ip: cks_is_ip, hdr_err: cks_hdr_err,
                   pay_err: cks_pay_err, pay_skip: cks_pay_skip};

   rfs_frame_track #(.CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_data   (in_data),
      .total_len (total_len),
      .type_val  (type_val)
   );

   rfs_giant_limit #(
      .CNT_W(CNT_W), .STD_MAX(STD_MAX), .TWOK_MAX(TWOK_MAX),
      .JUMBO_MAX(JUMBO_MAX), .VLAN_EXTRA(VLAN_EXTRA)
   ) u_giant (
      .total_len (total_len),
      .vlan      (side.vlan),
      .jumbo     (cfg_jumbo),
      .twok      (cfg_2k),
      .giant     (giant)
   );

   assign runt        = total_len < CNT_W'(HDR_BYTES);
   assign small_field = type_val < TYPE_LIM;
   assign len_coded   = runt || small_field;
   assign want_len    = {1'b0, type_val} + FIXED_OVH + (side.vlan ? TAG_OVH : '0);
   assign len_err     = !runt && small_field && !side.crc &&
                        (want_len != SUM_W'(total_len));

   rfs_cks_encode #(.HAS_CKS(HAS_CKS)) u_cks (
      .cks_on    (cfg_cks_en),
      .len_coded (len_coded),
      .giant     (giant),
      .cks       (cks),
      .b7        (b7),
      .b5        (b5),
      .b0        (b0)
   );

   always_comb begin
      word_d           = '0;
      word_d[B_CRC]    = side.crc;
      word_d[B_DRIB]   = side.drib;
      word_d[B_WDOG]   = side.wdog;
      word_d[B_OVF]    = side.ovf;
      word_d[B_VLAN]   = side.vlan;
      word_d[B_LENERR] = len_err;
      word_d[B_HI]     = b7;
      word_d[B_TYPE]   = b5;
      word_d[B_LO]     = b0;
      word_d[B_ESUM]   = side.crc | side.drib | side.wdog | side.ovf | len_err | giant;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_valid <= 1'b0;
         st_word  <= '0;
         st_len   <= '0;
         st_runt  <= 1'b0;
      end else begin
         st_valid <= in_valid && in_eof;
         if (in_valid && in_eof) begin
            st_word <= word_d;
            st_len  <= total_len;
            st_runt <= runt;
         end
      end
   end

   // R1
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> $past(in_valid && in_eof));
   // R5
   crc_masks_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_word[B_CRC]) |-> !st_word[B_LENERR]);
   // R3
   runt_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_runt) |-> (!st_word[B_TYPE] && !st_word[B_LENERR] &&
                                 st_len < CNT_W'(HDR_BYTES)));
   // R8
   esum_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && (st_word[B_CRC] || st_word[B_DRIB] || st_word[B_WDOG] ||
                    st_word[B_OVF] || st_word[B_LENERR])) |-> st_word[B_ESUM]);
   // R6
   giant_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_word[B_HI] && !$past(cfg_cks_en)) |-> (st_len > CNT_W'(STD_MAX)));
   // R2
   type_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_word[B_TYPE] && !$past(cfg_cks_en)) |-> (st_len >= CNT_W'(HDR_BYTES)));
endmodule

// File: tb/rx_frame_status_test.sv
`timescale 1ns/1ps
module rx_frame_status_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 0, in_sof = 0, in_eof = 0;
   logic [7:0] in_data = '0;
   logic in_crc_err = 0, in_dribble = 0, in_wdog = 0, in_ovf = 0, in_vlan = 0;
   logic cks_is_ip = 0, cks_hdr_err = 0, cks_pay_err = 0, cks_pay_skip = 0;
   logic cfg_jumbo = 0, cfg_2k = 0, cfg_cks_en = 0;
   logic        st_valid;
   logic [15:0] st_word;
   logic [13:0] st_len;
   logic        st_runt;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   rx_frame_status uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .in_crc_err(in_crc_err),
      .in_dribble(in_dribble), .in_wdog(in_wdog), .in_ovf(in_ovf),
      .in_vlan(in_vlan), .cks_is_ip(cks_is_ip), .cks_hdr_err(cks_hdr_err),
      .cks_pay_err(cks_pay_err), .cks_pay_skip(cks_pay_skip),
      .cfg_jumbo(cfg_jumbo), .cfg_2k(cfg_2k), .cfg_cks_en(cfg_cks_en),
      .st_valid(st_valid), .st_word(st_word), .st_len(st_len), .st_runt(st_runt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] model(input int len, input int typ);
      logic runt, lc, le, giant, b5, b7, b0;
      int limit;
      logic [15:0] w;
      runt = len < 14;
      lc   = runt || typ < 1536;
      le   = !runt && typ < 1536 && !in_crc_err && (typ + 18 + (in_vlan ? 4 : 0) != len);
      if (cfg_jumbo)   limit = in_vlan ? 9022 : 9018;
      else if (cfg_2k) limit = 2000;
      else             limit = in_vlan ? 1522 : 1518;
      giant = len > limit;
      if (!cfg_cks_en)       {b5, b7, b0} = {!lc, giant, 1'b0};
      else if (lc)           {b5, b7, b0} = 3'b000;
      else if (!cks_is_ip)   {b5, b7, b0} = 3'b011;
      else if (cks_hdr_err)  {b5, b7, b0} = 3'b111;
      else if (cks_pay_skip) {b5, b7, b0} = 3'b001;
      else if (cks_pay_err)  {b5, b7, b0} = 3'b101;
      else                   {b5, b7, b0} = 3'b100;
      w = '0;
      w[1] = in_crc_err; w[2] = in_dribble; w[4] = in_wdog; w[11] = in_ovf;
      w[10] = in_vlan; w[12] = le; w[5] = b5; w[7] = b7; w[0] = b0;
      w[15] = in_crc_err | in_dribble | in_wdog | in_ovf | le | giant;
      return w;
   endfunction

   task automatic frame(input int len, input int typ, input string req);
      logic [15:0] t;
      t = 16'(typ);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == len - 1);
         in_data  = (i == 12) ? t[15:8] : (i == 13) ? t[7:0] : (8'(i) ^ 8'h5a);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      check({req, " strobe R1"}, 32'(st_valid), 32'd1);
      check({req, " word"}, 32'(st_word), 32'(model(len, typ)));
      check({req, " len R1"}, 32'(st_len), 32'(len));
      check({req, " runt R3"}, 32'(st_runt), 32'(len < 14));
      @(negedge clk);
      check({req, " strobe drop R1"}, 32'(st_valid), 32'd0);
   endtask

   task automatic clear_side();
      {in_crc_err, in_dribble, in_wdog, in_ovf, in_vlan} = '0;
      {cks_is_ip, cks_hdr_err, cks_pay_err, cks_pay_skip} = '0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R11 reset valid", 32'(st_valid), 32'd0);
      check("R11 reset word", 32'(st_word), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle word", 32'(st_word), 32'd0);

      // R2 R3: size sweep across the runt boundary, EtherType field
      for (int l = 1; l <= 40; l++) frame(l, 16'h0800, "R2 R3 sweep");
      // R2: type boundary
      frame(64, 1535, "R2 R4 type 1535");
      frame(64, 1536, "R2 type 1536");

      // R4: length-coded sweep, with and without tag
      for (int v = 0; v < 2; v++) begin
         in_vlan = v[0];
         for (int l = 14; l <= 90; l++) frame(l, 46, "R4 len sweep");
      end
      in_vlan = 1'b0;
      frame(64, 46, "R4 match");
      in_vlan = 1'b1; frame(68, 46, "R4 tag match"); in_vlan = 1'b0;

      // R5: CRC masks length error
      in_crc_err = 1'b1;
      frame(70, 46, "R5 crc mask");
      frame(64, 16'h0800, "R5 crc type");
      clear_side();

      // R7 R8: individual error inputs
      in_dribble = 1'b1; frame(64, 16'h0800, "R7 R8 dribble"); clear_side();
      in_wdog    = 1'b1; frame(64, 16'h0800, "R7 R8 wdog");    clear_side();
      in_ovf     = 1'b1; frame(64, 16'h0800, "R7 R8 ovf");     clear_side();
      in_vlan    = 1'b1; frame(64, 16'h0800, "R7 vlan");       clear_side();

      // R6 R8: giant boundaries in every mode
      for (int m = 0; m < 6; m++) begin
         int lim;
         cfg_jumbo = (m >= 4);
         cfg_2k    = (m == 2 || m == 3);
         in_vlan   = m[0];
         if (cfg_jumbo)   lim = in_vlan ? 9022 : 9018;
         else if (cfg_2k) lim = 2000;
         else             lim = in_vlan ? 1522 : 1518;
         frame(lim, 16'h0800, "R6 at limit");
         frame(lim + 1, 16'h0800, "R6 R8 over limit");
      end
      cfg_jumbo = 1'b0; cfg_2k = 1'b0; clear_side();

      // R9 R10: checksum verdict, all input combinations in both classes
      cfg_cks_en = 1'b1;
      for (int c = 0; c < 16; c++) begin
         {cks_is_ip, cks_hdr_err, cks_pay_err, cks_pay_skip} = 4'(c);
         frame(64, 16'h0800, "R9 cks type");
         frame(64, 46, "R10 cks len-coded");
      end
      {cks_is_ip, cks_hdr_err, cks_pay_err, cks_pay_skip} = 4'b1010;
      frame(10, 16'h0800, "R10 cks runt");
      frame(1600, 16'h0800, "R8 R9 cks giant");
      cfg_cks_en = 1'b0; clear_side();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule